// File: doc/BRIEF.md
# DRAM Controller Performance Counter Unit

This unit counts eight fixed kinds of activity in a DRAM controller. Each of its eight 32-bit counters is tied to a single event pulse input, so there is nothing to select. Software starts and stops counting with one global enable bit and one enable bit per counter. It can preload any counter with a start value and reads counters back over a simple 32-bit register bus. The bus has a write strobe and a combinational read of the addressed register.

When a counter steps past its largest value, it wraps to zero and raises a sticky overflow status bit. Status bits are cleared by writing ones to a separate clear register. The single level interrupt output is high while any status bit is set whose mask bit is zero. After reset every interrupt is masked.

Top module: `dram_perf_counters`

## Requirements
- R1: After reset every counter, the control register, the enable register and the status register read 0, the mask register reads 0x000000FF, and irq is low.
- R2: Counter i advances by exactly one on each clock in which evt_pulse[i] is high and counting is enabled. It ignores every other event line. The counters for indices 0 to 7 are at byte offsets 0x380, 0x384, 0x388, 0x38C, 0x3C0, 0x3C4, 0x3CC and 0x3D0. Events 0 to 7 are, in order: write data, read data, write command, read command, precharge, activate, rank switch, and read/write turnaround.
- R3: Bit 1 of the control register at offset 0x010 is the global enable. While it is 0, no counter advances.
- R4: Bit i of the enable register at offset 0x6C0 gates counter i. A counter whose bit is 0 holds its value.
- R5: A bus write to a counter offset loads the written value. If the counter's event occurs in the same cycle, the written value wins.
- R6: A counter that increments from 0xFFFFFFFF becomes 0 and, in the same cycle, sets bit i of the status register at offset 0x6CC. This happens whatever the mask says.
- R7: Writing 1 to bit i of the clear register at offset 0x6D0 clears status bit i. Writing 0 to a bit leaves that status bit unchanged. If an overflow of counter i happens in the same cycle as its clear, status bit i stays set.
- R8: Bit i of the mask register at offset 0x6C8 masks status bit i when it is 1. irq is high exactly when some status bit is set and its mask bit is 0.
- R9: Reads of offsets that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_pulse | input | 8 | One event pulse line per counter |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check four things:
- a frozen counter holds its value while global counting is off;
- a counter wraps to zero and sets its status bit;
- a bus write wins over a same-cycle event;
- status bits stay set until a clear bit reaches them, and irq stays low while everything is masked.

Only the bench's scenarios can show the rest: that each counter is wired to its own event and sits at its own offset, the exact counts under mixed enable patterns, the mask-to-irq relation, the race between a clear and an overflow, and zero reads from holes in the map.

// File: rtl/dram_perf_counters.sv
module dram_perf_counters #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        evt_pulse,
  output logic              irq
);
  localparam int NUM_EV = 8;
  localparam int GEN_BIT = 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(12'h6C0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(12'h6C8);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(12'h6CC);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(12'h6D0);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  function automatic logic [ADDR_W-1:0] cnt_off(input int idx);
    case (idx)
      0: return ADDR_W'(12'h380);
      1: return ADDR_W'(12'h384);
      2: return ADDR_W'(12'h388);
      3: return ADDR_W'(12'h38C);
      4: return ADDR_W'(12'h3C0);
      5: return ADDR_W'(12'h3C4);
      6: return ADDR_W'(12'h3CC);
      default: return ADDR_W'(12'h3D0);
    endcase
  endfunction

  logic              run;
  logic [NUM_EV-1:0] ev_en, int_mask, ovf_sts;
  logic [NUM_EV-1:0] wr_hit, inc, wrap, clr_bits;
  logic [DATA_W-1:0] cnt [NUM_EV];

  assign clr_bits = (bus_wr && bus_addr == A_CLR) ? bus_wdata[NUM_EV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ev_en    <= '0;
      int_mask <= '1;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) run      <= bus_wdata[GEN_BIT];
      if (bus_addr == A_EN)   ev_en    <= bus_wdata[NUM_EV-1:0];
      if (bus_addr == A_MASK) int_mask <= bus_wdata[NUM_EV-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_sts <= '0;
    else        ovf_sts <= (ovf_sts & ~clr_bits) | wrap;
  end

  assign irq = |(ovf_sts & ~int_mask);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&int_mask) |-> !irq);

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
    localparam logic [ADDR_W-1:0] OFF = cnt_off(g);
    assign wr_hit[g] = bus_wr && (bus_addr == OFF);
    assign inc[g]    = run && ev_en[g] && evt_pulse[g];
    assign wrap[g]   = inc[g] && !wr_hit[g] && (cnt[g] == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt[g] <= '0;
      else if (wr_hit[g]) cnt[g] <= bus_wdata;
      else if (inc[g])   cnt[g] <= cnt[g] + 1'b1;
    end

    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_hit[g]) |=> $stable(cnt[g]));
    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> cnt[g] == $past(bus_wdata));
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[g] |=> (cnt[g] == '0) && ovf_sts[g]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sts[g] && !clr_bits[g]) |=> ovf_sts[g]);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[GEN_BIT] = run;
      A_EN:   bus_rdata[NUM_EV-1:0] = ev_en;
      A_MASK: bus_rdata[NUM_EV-1:0] = int_mask;
      A_STS:  bus_rdata[NUM_EV-1:0] = ovf_sts;
      default: ;
    endcase
    for (int i = 0; i < NUM_EV; i++)
      if (bus_addr == cnt_off(i)) bus_rdata = cnt[i];
  end
endmodule

// File: tb/dram_perf_counters_tb.sv
module dram_perf_counters_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] exp_cnt [8];
  logic [11:0] offs [8];

  always #4 clk = ~clk;

  dram_perf_counters dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [7:0] ev);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; evt_pulse = ev;
    @(negedge clk);
    bus_wr = 0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [7:0] ev, input int n);
    @(negedge clk);
    evt_pulse = ev;
    repeat (n) @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 8; i++) rd(req, offs[i], exp_cnt[i]);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    offs[0] = 12'h380; offs[1] = 12'h384; offs[2] = 12'h388; offs[3] = 12'h38C;
    offs[4] = 12'h3C0; offs[5] = 12'h3C4; offs[6] = 12'h3CC; offs[7] = 12'h3D0;
    for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_all("R1");
    rd("R1", 12'h010, 0); rd("R1", 12'h6C0, 0);
    rd("R1", 12'h6C8, 32'hFF); rd("R1", 12'h6CC, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    // R3 nothing counts with everything off
    pulse(8'hFF, 4);
    chk_all("R3");
    // R2 each event to its own counter
    wr(12'h010, 32'h2, 0);
    wr(12'h6C0, 32'hFF, 0);
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i), 3 * (i + 1));
      exp_cnt[i] += 3 * (i + 1);
      chk_all("R2");
    end
    // R3 global disable freezes all
    wr(12'h010, 32'h0, 0);
    pulse(8'hFF, 5);
    chk_all("R3");
    // R4 per-counter enables
    wr(12'h010, 32'h2, 0);
    wr(12'h6C0, 32'h55, 0);
    pulse(8'hFF, 4);
    for (int i = 0; i < 8; i += 2) exp_cnt[i] += 4;
    chk_all("R4");
    wr(12'h6C0, 32'hFF, 0);
    // R5 write beats a same-cycle event
    wr(12'h38C, 32'h1234_5678, 8'h08);
    exp_cnt[3] = 32'h1234_5678;
    chk_all("R5");
    // R6 overflow on every counter, masked
    for (int i = 0; i < 8; i++) begin
      wr(offs[i], 32'hFFFF_FFFE, 0);
      exp_cnt[i] = 0;
    end
    pulse(8'hFF, 2);
    chk_all("R6");
    rd("R6", 12'h6CC, 32'hFF);
    chk("R6 irq masked", {31'b0, irq}, 0);
    // R8 mask
    wr(12'h6C8, 32'hFE, 0);
    chk("R8 irq", {31'b0, irq}, 1);
    // R7 clear, zero-write no effect
    wr(12'h6D0, 32'h00, 0);
    rd("R7", 12'h6CC, 32'hFF);
    wr(12'h6D0, 32'h01, 0);
    rd("R7", 12'h6CC, 32'hFE);
    chk("R8 irq after clear", {31'b0, irq}, 0);
    wr(12'h6C8, 32'h00, 0);
    chk("R8 irq unmasked", {31'b0, irq}, 1);
    wr(12'h6D0, 32'hFF, 0);
    rd("R7", 12'h6CC, 0);
    chk("R8 irq none", {31'b0, irq}, 0);
    // R7 clear races overflow
    wr(12'h388, 32'hFFFF_FFFF, 0);
    wr(12'h6D0, 32'h04, 8'h04);
    rd("R7 race", 12'h6CC, 32'h04);
    rd("R7 race", 12'h388, 0);
    chk("R8 irq race", {31'b0, irq}, 1);
    // R9 holes
    rd("R9", 12'h000, 0); rd("R9", 12'h390, 0);
    rd("R9", 12'h3C8, 0); rd("R9", 12'h6C4, 0);
    rd("R9", 12'hFFC, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule